// File: doc/BRIEF.md
# Machine-Mode Trap Entry Unit

This unit performs synchronous exception entry for a small 32-bit core that runs only in machine mode. The pipeline raises a one-cycle trap request together with a 3-bit cause selector, the program counter of the faulting instruction, a candidate trap value and the byte length of that instruction. In the same cycle the unit returns a redirect target with a valid strobe. On the next clock edge it updates its exception-PC, cause and trap-value registers.

The unit also holds a software-writable trap-vector register. Bits [1:0] of that register select the mode and bits [31:2] hold the handler base. If the whole register is zero, software has not configured it. In that case the unit does not vector to a handler. It records the trap and then resumes execution just past the faulting instruction.

All four registers are visible on output ports at all times, so the surrounding CSR read path can return them without waiting a cycle.

Top module: `mtrap_entry`

## Requirements
- R1: The selector maps to cause codes as follows: 0 gives 0 (fetch misaligned), 1 gives 2 (illegal instruction), 2 gives 3 (breakpoint), 3 gives 4 (load misaligned), 4 gives 6 (store/AMO misaligned) and 5 gives 11 (machine environment call). The cause register holds that code from the cycle after an accepted trap.
- R2: After an accepted trap the exception-PC register holds the request PC. When the trap-vector register is zero it instead holds the request PC plus the instruction length.
- R3: After an accepted trap the trap-value register holds the supplied trap value. Selector 2 (breakpoint) is the exception: it stores the request PC. Selector 5 (environment call) is the other exception: it stores zero.
- R4: When the trap-vector register is nonzero and its mode bits [1:0] are 0, 2 or 3, the redirect PC is the register with bits [1:0] cleared.
- R5: When the trap-vector register is nonzero and its mode bits are 1, the redirect PC is the base (bits [1:0] cleared) plus 4 times the cause code.
- R6: When the trap-vector register is zero, the redirect PC is the request PC plus the instruction length. The instruction length is 2 or 4.
- R7: The redirect-valid output is high in exactly the cycle in which a trap with selector 0 to 5 is requested, and low in every other cycle.
- R8: The trap-vector register resets to zero. A write loads it from the next cycle on. A trap requested in the same cycle as a write uses the old register value.
- R9: Selectors 6 and 7 are ignored. The unit gives no redirect and leaves the exception-PC, cause and trap-value registers unchanged.
- R10: Reset clears the exception-PC, cause and trap-value registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | One-cycle trap request |
| trap_sel | input | 3 | Cause selector (encoding in R1) |
| cur_pc | input | 32 | PC of the trapping instruction |
| trap_val | input | 32 | Supplied trap value |
| insn_len | input | 3 | Byte length of the trapping instruction (2 or 4) |
| vec_wr_en | input | 1 | Trap-vector register write enable |
| vec_wr_data | input | 32 | Trap-vector register write data |
| epc_o | output | 32 | Exception-PC register |
| cause_o | output | 32 | Cause register |
| tval_o | output | 32 | Trap-value register |
| vec_o | output | 32 | Trap-vector register |
| redir_valid | output | 1 | Redirect strobe |
| redir_pc | output | 32 | Redirect target |

## Verification
Traps are raised with every selector under each form of the trap-vector register: all zero, direct with mode 0, modes 2 and 3 carrying nonzero low bits, vectored with a nonzero base, and vectored with a zero base (value 1). The vectored runs separate the cause-scaled offset from a plain base jump. The zero-base vectored value separates "whole register zero" from "base zero", which is the condition that selects the fallback. Fallback traps with lengths 2 and 4 show that both the redirect and the stored exception PC take the increment. Breakpoint and environment-call traps with a non-trivial supplied value expose the trap-value overrides. Invalid selectors and a write that coincides with a trap check that nothing is written and that the old vector value is used.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;

    localparam int XLEN_DEF  = 32;
    localparam int SEL_W     = 3;
    localparam int CODE_W    = 5;
    localparam int MODE_W    = 2;
    localparam int LEN_W     = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_FETCH_MISAL = 3'd0,
        SEL_ILLEGAL     = 3'd1,
        SEL_BRKPT       = 3'd2,
        SEL_LOAD_MISAL  = 3'd3,
        SEL_STORE_MISAL = 3'd4,
        SEL_ENV_CALL    = 3'd5
    } trap_sel_e;

    typedef enum logic [1:0] {
        TV_SUPPLIED = 2'd0,
        TV_FROM_PC  = 2'd1,
        TV_ZERO     = 2'd2
    } tval_src_e;

    localparam logic [MODE_W-1:0] MODE_VECTORED = 2'd1;

endpackage

// File: rtl/mtrap_cause_map.sv
module mtrap_cause_map
    import mtrap_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    output logic              sel_ok,
    output logic [CODE_W-1:0] code,
    output tval_src_e         tval_src
);

    always_comb begin
        sel_ok   = 1'b1;
        code     = '0;
        tval_src = TV_SUPPLIED;
        case (sel)
            SEL_FETCH_MISAL: code = 5'd0;
            SEL_ILLEGAL:     code = 5'd2;
            SEL_BRKPT: begin
                code     = 5'd3;
                tval_src = TV_FROM_PC;
            end
            SEL_LOAD_MISAL:  code = 5'd4;
            SEL_STORE_MISAL: code = 5'd6;
            SEL_ENV_CALL: begin
                code     = 5'd11;
                tval_src = TV_ZERO;
            end
            default:         sel_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/mtrap_vec_reg.sv
module mtrap_vec_reg #(
    parameter int XLEN = mtrap_pkg::XLEN_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] vec_q
);

    logic [XLEN-1:0] vec_d;

    always_comb begin
        vec_d = vec_q;
        if (wr_en) vec_d = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vec_q <= '0;
        else        vec_q <= vec_d;
    end

    // R8
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(vec_q));

    // R8
    vec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vec_q == $past(wr_data));

endmodule

// File: rtl/mtrap_target.sv
module mtrap_target
    import mtrap_pkg::*;
#(
    parameter int XLEN = XLEN_DEF
) (
    input  logic [XLEN-1:0]   vec,
    input  logic [CODE_W-1:0] code,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [LEN_W-1:0]  insn_len,
    output logic              fallback,
    output logic [XLEN-1:0]   resume_pc,
    output logic [XLEN-1:0]   target_pc
);

    localparam int ENTRY_SHIFT = 2;

    logic [XLEN-1:0]   base;
    logic [MODE_W-1:0] mode;
    logic [XLEN-1:0]   offset;

    always_comb begin
        base      = {vec[XLEN-1:MODE_W], {MODE_W{1'b0}}};
        mode      = vec[MODE_W-1:0];
        offset    = XLEN'(code) << ENTRY_SHIFT;
        fallback  = (vec == '0);
        resume_pc = cur_pc + XLEN'(insn_len);
        if (fallback)                   target_pc = resume_pc;
        else if (mode == MODE_VECTORED) target_pc = base + offset;
        else                            target_pc = base;
    end

endmodule

// File: rtl/mtrap_entry.sv
module mtrap_entry
    import mtrap_pkg::*;
#(
    parameter int XLEN = XLEN_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_req,
    input  logic [SEL_W-1:0]  trap_sel,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   trap_val,
    input  logic [LEN_W-1:0]  insn_len,
    input  logic              vec_wr_en,
    input  logic [XLEN-1:0]   vec_wr_data,
    output logic [XLEN-1:0]   epc_o,
    output logic [XLEN-1:0]   cause_o,
    output logic [XLEN-1:0]   tval_o,
    output logic [XLEN-1:0]   vec_o,
    output logic              redir_valid,
    output logic [XLEN-1:0]   redir_pc
);

    typedef struct packed {
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] tval;
    } trap_csr_t;

    trap_csr_t st_d, st_q;

    logic              sel_ok;
    logic [CODE_W-1:0] code;
    tval_src_e         tval_src;
    logic              fallback;
    logic [XLEN-1:0]   resume_pc;
    logic [XLEN-1:0]   target_pc;
    logic              take;

    mtrap_cause_map u_cause (
        .sel      (trap_sel),
        .sel_ok   (sel_ok),
        .code     (code),
        .tval_src (tval_src)
    );

    mtrap_vec_reg #(.XLEN(XLEN)) u_vec (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (vec_wr_en),
        .wr_data (vec_wr_data),
        .vec_q   (vec_o)
    );

    mtrap_target #(.XLEN(XLEN)) u_tgt (
        .vec       (vec_o),
        .code      (code),
        .cur_pc    (cur_pc),
        .insn_len  (insn_len),
        .fallback  (fallback),
        .resume_pc (resume_pc),
        .target_pc (target_pc)
    );

    always_comb begin
        take = trap_req && sel_ok;
        st_d = st_q;
        if (take) begin
            st_d.epc   = fallback ? resume_pc : cur_pc;
            st_d.cause = XLEN'(code);
            case (tval_src)
                TV_FROM_PC: st_d.tval = cur_pc;
                TV_ZERO:    st_d.tval = '0;
                default:    st_d.tval = trap_val;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign epc_o       = st_q.epc;
    assign cause_o     = st_q.cause;
    assign tval_o      = st_q.tval;
    assign redir_valid = take;
    assign redir_pc    = target_pc;

    // R7
    redir_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> trap_req);

    // R1
    cause_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cause_o inside {32'd0, 32'd2, 32'd3, 32'd4, 32'd6, 32'd11});

    // R2
    epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> epc_o == $past(cur_pc)
            + (($past(vec_o) == '0) ? XLEN'($past(insn_len)) : '0));

    // R9
    bad_sel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && trap_sel > 3'd5) |=>
            $stable(epc_o) && $stable(cause_o) && $stable(tval_o));

    // R6
    fallback_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_valid && vec_o == '0) |-> redir_pc == cur_pc + XLEN'(insn_len));

    // R4
    vectored_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_valid && vec_o != '0) |-> redir_pc[1:0] == 2'b00);

endmodule

// File: tb/mtrap_entry_tb.sv
`timescale 1ns/1ps
module mtrap_entry_tb_top;

    typedef struct {
        logic [31:0] epc;
        logic [31:0] cause;
        logic [31:0] tval;
        logic [31:0] vec;
        string       tag;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        trap_req;
    logic [2:0]  trap_sel;
    logic [31:0] cur_pc, trap_val;
    logic [2:0]  insn_len;
    logic        vec_wr_en;
    logic [31:0] vec_wr_data;
    logic [31:0] epc_o, cause_o, tval_o, vec_o, redir_pc;
    logic        redir_valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    exp_item_t q[$];
    logic [31:0] m_epc, m_cause, m_tval, m_vec;

    always #5 clk = ~clk;

    mtrap_entry dut_i (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_sel(trap_sel),
        .cur_pc(cur_pc), .trap_val(trap_val), .insn_len(insn_len),
        .vec_wr_en(vec_wr_en), .vec_wr_data(vec_wr_data),
        .epc_o(epc_o), .cause_o(cause_o), .tval_o(tval_o), .vec_o(vec_o),
        .redir_valid(redir_valid), .redir_pc(redir_pc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] code_of(input logic [2:0] s);
        case (s)
            3'd0: return 32'd0;
            3'd1: return 32'd2;
            3'd2: return 32'd3;
            3'd3: return 32'd4;
            3'd4: return 32'd6;
            default: return 32'd11;
        endcase
    endfunction

    function automatic logic [31:0] exp_target(input logic [31:0] v, input logic [2:0] s,
                                               input logic [31:0] pc, input logic [2:0] len);
        if (v == 32'd0)          return pc + 32'(len);
        if (v[1:0] == 2'd1)      return {v[31:2], 2'b00} + (code_of(s) << 2);
        return {v[31:2], 2'b00};
    endfunction

    function automatic void push(input string tag);
        exp_item_t it;
        it.epc = m_epc; it.cause = m_cause; it.tval = m_tval; it.vec = m_vec; it.tag = tag;
        q.push_back(it);
    endfunction

    // driver: one request cycle, optionally with a coincident vector write
    task automatic drive(input bit do_trap, input logic [2:0] s, input logic [31:0] pc,
                         input logic [31:0] val, input logic [2:0] len,
                         input bit do_wr, input logic [31:0] wd, input string tag);
        logic [31:0] tgt;
        @(negedge clk);
        trap_req = do_trap; trap_sel = s; cur_pc = pc; trap_val = val; insn_len = len;
        vec_wr_en = do_wr; vec_wr_data = wd;
        #1;
        if (do_trap && s <= 3'd5) begin
            tgt = exp_target(m_vec, s, pc, len);
            chk({tag, " R7 valid"}, {31'd0, redir_valid}, 32'd1);
            chk({tag, " redirect"}, redir_pc, tgt);
            m_epc   = (m_vec == 32'd0) ? pc + 32'(len) : pc;
            m_cause = code_of(s);
            m_tval  = (s == 3'd2) ? pc : (s == 3'd5) ? 32'd0 : val;
        end else begin
            chk({tag, " R7 idle"}, {31'd0, redir_valid}, 32'd0);
        end
        if (do_wr) m_vec = wd;
        push(tag);
        @(posedge clk);
        @(negedge clk);
        trap_req = 1'b0; vec_wr_en = 1'b0;
        #1;
        chk({tag, " R7 single pulse"}, {31'd0, redir_valid}, 32'd0);
    endtask

    // monitor: compare registered state after each edge that follows a push
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_item_t it;
                it = q.pop_front();
                chk({it.tag, " R2 epc"},   epc_o,   it.epc);
                chk({it.tag, " R1 cause"}, cause_o, it.cause);
                chk({it.tag, " R3 tval"},  tval_o,  it.tval);
                chk({it.tag, " R8 vec"},   vec_o,   it.vec);
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; trap_req = 1'b0; trap_sel = '0; cur_pc = '0; trap_val = '0;
        insn_len = 3'd4; vec_wr_en = 1'b0; vec_wr_data = '0;
        m_epc = '0; m_cause = '0; m_tval = '0; m_vec = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10 R8 reset state
        chk("R10 epc reset", epc_o, 32'd0);
        chk("R10 cause reset", cause_o, 32'd0);
        chk("R10 tval reset", tval_o, 32'd0);
        chk("R8 vec reset", vec_o, 32'd0);
        chk("R7 reset idle", {31'd0, redir_valid}, 32'd0);

        // R6 fallback with 4- and 2-byte instructions, R3 overrides
        drive(1, 3'd5, 32'h0000_0100, 32'h1234_5678, 3'd4, 0, 0, "R6 ecall fallback");
        drive(1, 3'd2, 32'h0000_0200, 32'h5555_aaaa, 3'd2, 0, 0, "R6 brkpt fallback len2");
        // R9 invalid selectors
        drive(1, 3'd6, 32'h0000_0300, 32'hffff_0000, 3'd4, 0, 0, "R9 sel6");
        drive(1, 3'd7, 32'h0000_0304, 32'hffff_0001, 3'd4, 0, 0, "R9 sel7");
        // R4 direct mode 0
        drive(0, 3'd0, 0, 0, 3'd4, 1, 32'h8000_0000, "R8 write direct");
        drive(1, 3'd1, 32'h0000_0400, 32'hdead_beef, 3'd4, 0, 0, "R4 illegal direct");
        drive(1, 3'd4, 32'h0000_0404, 32'h0000_0007, 3'd4, 0, 0, "R4 store direct");
        // R5 vectored mode
        drive(0, 3'd0, 0, 0, 3'd4, 1, 32'h8000_0001, "R8 write vectored");
        for (int s = 0; s < 6; s++)
            drive(1, 3'(s), 32'h0000_1000 + 32'(s * 4), 32'hc0de_0000 + 32'(s), 3'd4, 0, 0,
                  "R5 vectored sweep");
        // R4 modes 2 and 3 act as direct
        drive(0, 3'd0, 0, 0, 3'd4, 1, 32'h8000_0102, "R8 write mode2");
        drive(1, 3'd3, 32'h0000_2000, 32'h0000_2001, 3'd4, 0, 0, "R4 mode2 load");
        drive(0, 3'd0, 0, 0, 3'd4, 1, 32'h8000_0103, "R8 write mode3");
        drive(1, 3'd5, 32'h0000_2100, 32'h7777_7777, 3'd2, 0, 0, "R4 mode3 ecall");
        // R5 zero base vectored is not fallback
        drive(0, 3'd0, 0, 0, 3'd4, 1, 32'h0000_0001, "R8 write base0 vectored");
        drive(1, 3'd4, 32'h0000_3000, 32'h0000_3003, 3'd2, 0, 0, "R5 base0 store");
        // R8 write coincident with trap uses old value
        drive(1, 3'd1, 32'h0000_4000, 32'h0bad_0bad, 3'd4, 1, 32'h0000_0000, "R8 write+trap old vec");
        drive(1, 3'd0, 32'h0000_5000, 32'h0000_5002, 3'd2, 0, 0, "R6 after clearing vec");
        drive(1, 3'd7, 32'h0000_6000, 32'h0000_6000, 3'd4, 0, 0, "R9 sel7 after fallback");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule